// File: doc/BRIEF.md
# Slow-Clock SPI Byte Transceiver (Clock Polarity 1)

This block is a simple SPI master for a slow peripheral such as a touch-panel controller. The host writes a word. The low byte of that word is sent on the serial data output, most significant bit first. During the same transfer, eight bits arriving on the serial data input are assembled into a received byte. Each bit is stretched over many system clocks so that the serial rate stays far below the system rate. The serial clock has polarity 1, so it rests high between transfers.

A single host read returns two things together: a busy flag in the top bit and the most recently received byte in the low bits. Software writes a byte, polls until the busy flag clears, and then takes the received byte from the same read word. Chip-select control and the command protocol of the peripheral are handled outside this block.

Top module: `spi_slow_xcvr`

## Requirements
- R1: After reset, `host_rdata` reads 0, `ser_clk` is 1 and `ser_out` is 0.
- R2: A one-cycle pulse on `host_wr` captures only `host_wdata[7:0]` as the byte to send. Bits 15..8 of the write word have no effect on `ser_out` or on the received byte. `host_rdata[15]` reads 1 from the cycle after the pulse.
- R3: `host_rdata[15]` stays 1 for exactly 256 consecutive cycles after the write edge, then reads 0.
- R4: `host_rdata[14:8]` always reads 0.
- R5: Bit k of the transfer (k = 0..7) occupies write-relative cycles 32k+1 to 32k+32. During that window `ser_out` carries `host_wdata[7-k]`, so the byte leaves most significant bit first.
- R6: Within each bit window, `ser_clk` is high for the first 16 cycles and low for the last 16. It is forced high by a write and is high again once the transfer ends.
- R7: `ser_in` is captured at the middle of each bit window (the cycle where `ser_clk` goes low). It enters the shift register at the end of the window. When busy clears, `host_rdata[7:0]` equals the eight captured bits, first captured bit in bit 7.
- R8: While idle and with no write, `host_rdata[7:0]` and `ser_clk` hold their values whatever `ser_in` and `host_wdata` do.
- R9: A write while busy restarts the transfer. It reloads the send byte, sets `ser_clk` high and begins a new full 256-cycle window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | One-cycle write strobe that starts a transfer |
| host_wdata | input | 16 | Write word; the low byte is the byte to send |
| host_rdata | output | 16 | Read word: bit 15 busy, bits 14..8 zero, bits 7..0 shift register / received byte |
| ser_out | output | 1 | Serial data to the peripheral |
| ser_in | input | 1 | Serial data from the peripheral |
| ser_clk | output | 1 | Serial clock, idles high |

## Verification
The bench builds the block with its defaults: 16 system clocks per serial-clock half period, 8-bit frames and a 16-bit host word. This gives a 256-cycle transfer, short enough for a dozen full frames plus idle stretches within the run. With these values every bit window can be checked at a fixed offset from the write edge: serial clock level and output bit at the quarter points, and the received byte at the cycle busy drops. A write issued in the middle of a frame makes the restart path reachable. Randomized bytes on both the send and receive sides cover both bit polarities in every position.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
  // Default geometry of one transfer
  localparam int unsigned DEF_HALF_CLKS = 16; // system clocks per serial-clock half period
  localparam int unsigned DEF_FRAME_BITS = 8; // bits exchanged per transfer
  localparam int unsigned DEF_HOST_W = 16;    // host word width

  // Activity of one system cycle as seen by the datapath
  typedef struct packed {
    logic start;  // write strobe accepted
    logic tick;   // serial-clock edge cycle
    logic busy;   // transfer in progress
  } xfer_ctl_t;
endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/spi_bit_timer.sv
module spi_bit_timer #(
  parameter int unsigned HALF_CLKS = spi_xcvr_pkg::DEF_HALF_CLKS,
  parameter int unsigned FRAME_BITS = spi_xcvr_pkg::DEF_FRAME_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output spi_xcvr_pkg::xfer_ctl_t ctl
);
  localparam int unsigned TOTAL = 2 * HALF_CLKS * FRAME_BITS;
  localparam int unsigned CW = $clog2(TOTAL + 1);
  localparam int unsigned PW = $clog2(HALF_CLKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] phase_q, phase_d;
  logic busy, at_end, at_half;

  assign busy    = (cnt_q != '0);
  assign at_end  = (cnt_q == CW'(TOTAL));
  assign at_half = (phase_q == PW'(HALF_CLKS));

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (start) begin
      cnt_d   = CW'(1);
      phase_d = PW'(1);
    end else if (at_end) begin
      cnt_d   = '0;
      phase_d = '0;
    end else if (busy) begin
      cnt_d   = cnt_q + 1'b1;
      phase_d = at_half ? PW'(1) : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign ctl.start = start;
  assign ctl.tick  = busy && at_half;
  assign ctl.busy  = busy;
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen (
  input  logic clk,
  input  logic rst_n,
  input  spi_xcvr_pkg::xfer_ctl_t ctl,
  output logic sclk
);
  logic sclk_q, sclk_d;

  always_comb begin
    sclk_d = sclk_q;
    if (ctl.start)     sclk_d = 1'b1;
    else if (ctl.tick) sclk_d = ~sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= sclk_d;
  end

  assign sclk = sclk_q;
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned FRAME_BITS = spi_xcvr_pkg::DEF_FRAME_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  spi_xcvr_pkg::xfer_ctl_t ctl,
  input  logic sclk_level,
  input  logic [FRAME_BITS-1:0] load_byte,
  input  logic sdi,
  output logic [FRAME_BITS-1:0] shreg
);
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic hold_q, hold_d;
  logic cap_en, shift_en;

  // Mid-bit tick (clock high, about to fall) captures; end-of-bit tick shifts
  assign cap_en   = ctl.tick &&  sclk_level;
  assign shift_en = ctl.tick && !sclk_level;

  always_comb begin
    hold_d = hold_q;
    if (cap_en) hold_d = sdi;
  end

  always_comb begin
    sh_d = sh_q;
    if (ctl.start)     sh_d = load_byte;
    else if (shift_en) sh_d = {sh_q[FRAME_BITS-2:0], hold_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      hold_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      hold_q <= hold_d;
    end
  end

  assign shreg = sh_q;
endmodule

// File: rtl/spi_slow_xcvr.sv
module spi_slow_xcvr #(
  parameter int unsigned HALF_CLKS = spi_xcvr_pkg::DEF_HALF_CLKS,
  parameter int unsigned FRAME_BITS = spi_xcvr_pkg::DEF_FRAME_BITS,
  parameter int unsigned HOST_W = spi_xcvr_pkg::DEF_HOST_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_wr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic ser_out,
  input  logic ser_in,
  output logic ser_clk
);
  localparam int unsigned PAD_W = HOST_W - 1 - FRAME_BITS;

  logic rst_n_sync;
  spi_xcvr_pkg::xfer_ctl_t ctl;
  logic [FRAME_BITS-1:0] shreg;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^host_wdata[HOST_W-1:FRAME_BITS];

  spi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  spi_bit_timer #(.HALF_CLKS(HALF_CLKS), .FRAME_BITS(FRAME_BITS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .start (host_wr),
    .ctl   (ctl)
  );

  spi_sclk_gen u_sclk (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .ctl   (ctl),
    .sclk  (ser_clk)
  );

  spi_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .ctl        (ctl),
    .sclk_level (ser_clk),
    .load_byte  (host_wdata[FRAME_BITS-1:0]),
    .sdi        (ser_in),
    .shreg      (shreg)
  );

  assign ser_out    = shreg[FRAME_BITS-1];
  assign host_rdata = {ctl.busy, {PAD_W{1'b0}}, shreg};
endmodule

// File: rtl/spi_slow_xcvr_chk.sv
module spi_slow_xcvr_chk #(
  parameter int unsigned HALF_CLKS = 16,
  parameter int unsigned FRAME_BITS = 8,
  parameter int unsigned HOST_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic host_wr,
  input logic [HOST_W-1:0] host_rdata,
  input logic ser_clk
);
  localparam int unsigned TOTAL = 2 * HALF_CLKS * FRAME_BITS;
  localparam int unsigned CW = $clog2(TOTAL + 1);

  logic busy;
  logic [CW-1:0] win_q;

  assign busy = host_rdata[HOST_W-1];

  // Independent window counter measured from the last write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    win_q <= '0;
    else if (host_wr)              win_q <= CW'(1);
    else if (win_q == CW'(TOTAL))  win_q <= '0;
    else if (win_q != '0)          win_q <= win_q + 1'b1;
  end

  a_r2_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> busy);

  a_r3_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (win_q != '0));

  a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[HOST_W-2:FRAME_BITS] == '0);

  a_r6_clk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_clk);

  a_r9_write_forces_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> ser_clk);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !host_wr) |=> $stable(host_rdata[FRAME_BITS-1:0]));
endmodule

bind spi_slow_xcvr spi_slow_xcvr_chk #(
  .HALF_CLKS(HALF_CLKS), .FRAME_BITS(FRAME_BITS), .HOST_W(HOST_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .host_wr    (host_wr),
  .host_rdata (host_rdata),
  .ser_clk    (ser_clk)
);

// File: tb/test_spi_slow_xcvr.sv
`timescale 1ns/1ps
module test_spi_slow_xcvr;
  localparam int HALF = 16;
  localparam int BITW = 2 * HALF;
  localparam int NB = 8;
  localparam int TOTAL = BITW * NB;
  localparam int WATCHDOG = 100000;

  logic clk;
  logic rst_n;
  logic host_wr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic ser_out, ser_in, ser_clk;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  spi_slow_xcvr i_spi_slow_xcvr (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ser_out(ser_out), .ser_in(ser_in), .ser_clk(ser_clk)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] expect_done(input logic [7:0] rx);
    return {8'h00, rx};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // One transfer; stop_at < TOTAL abandons it after that many cycles
  task automatic xfer(input logic [15:0] wword, input logic [7:0] rx,
                      input int stop_at, input bit restart);
    string tg_sdo, tg_clk;
    tg_sdo = restart ? "R9/R5" : "R5";
    tg_clk = restart ? "R9/R6" : "R6";
    @(negedge clk);
    host_wdata = wword;
    host_wr = 1'b1;
    ser_in = rx[NB-1];
    @(posedge clk);
    for (int c = 1; c <= TOTAL; c++) begin
      @(negedge clk);
      if (c == 1) begin
        host_wr = 1'b0;
        host_wdata = 16'($urandom);
        check("R2 busy set", {15'd0, host_rdata[15]}, 16'd1);
        check("R2 first bit", {15'd0, ser_out}, {15'd0, wword[NB-1]});
        check(restart ? "R9 clk forced high" : "R6 clk forced high", {15'd0, ser_clk}, 16'd1);
      end
      check(restart ? "R9/R3 busy held" : "R3 busy held", {15'd0, host_rdata[15]}, 16'd1);
      check("R4 pad zero", {9'd0, host_rdata[14:8]}, 16'd0);
      if (c % BITW == 8) begin
        check(tg_sdo, {15'd0, ser_out}, {15'd0, wword[NB-1-c/BITW]});
        check(tg_clk, {15'd0, ser_clk}, 16'd1);
      end
      if (c % BITW == 24) begin
        check(tg_sdo, {15'd0, ser_out}, {15'd0, wword[NB-1-c/BITW]});
        check(tg_clk, {15'd0, ser_clk}, 16'd0);
      end
      if (c == stop_at) return;
      if (c % BITW == 0 && c < TOTAL) ser_in = rx[NB-1-c/BITW];
      @(posedge clk);
    end
    @(negedge clk);
    check(restart ? "R9/R3 busy clear" : "R3 busy clear", {15'd0, host_rdata[15]}, 16'd0);
    check(restart ? "R9/R7 received" : "R7 received", host_rdata, expect_done(rx));
    check("R6 clk idle high", {15'd0, ser_clk}, 16'd1);
  endtask

  task automatic idle_hold(input int n, input logic [7:0] rx);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ser_in = 1'($urandom);
      host_wdata = 16'($urandom);
      if (i % 8 == 7) begin
        check("R8 byte held", host_rdata, expect_done(rx));
        check("R8 clk held", {15'd0, ser_clk}, 16'd1);
      end
    end
  endtask

  initial begin
    logic [15:0] w;
    logic [7:0] r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    host_wr = 1'b0;
    host_wdata = 16'h0;
    ser_in = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 rdata", host_rdata, 16'h0000);
    check("R1 clk", {15'd0, ser_clk}, 16'd1);
    check("R1 sdo", {15'd0, ser_out}, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Directed corners: upper write bits set, all ones / zeros, alternating
    xfer(16'hFF00, 8'hFF, TOTAL, 0);
    idle_hold(20, 8'hFF);
    xfer(16'h00FF, 8'h00, TOTAL, 0);
    xfer(16'hA5A5, 8'h5A, TOTAL, 0);
    idle_hold(16, 8'h5A);
    xfer(16'h7E01, 8'h80, TOTAL, 0);

    // Restart while busy
    xfer(16'h00C3, 8'h3C, 100, 0);
    xfer(16'h0096, 8'h69, TOTAL, 1);
    xfer(16'h0011, 8'h22, TOTAL - 1, 0);
    xfer(16'h00E7, 8'h18, TOTAL, 1);

    // Random traffic
    for (int k = 0; k < 8; k++) begin
      w = 16'($urandom);
      r = 8'($urandom);
      xfer(w, r, TOTAL, 0);
      idle_hold(8 + (k % 3) * 8, r);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule